// File: doc/BRIEF.md
# Paged Address Translator with Access Codes and Write Locks

This block turns a virtual word address into a real memory address by looking up a page table of 512-word pages. When mapping is on, the page field of the virtual address selects a table entry, and that entry's real page number replaces the page field. The offset inside the page passes through unchanged. When mapping is off, the address passes through as it is. Addresses 0 through 15 select the general register file and never reach memory.

Each access is checked in two ways. The first is a two-bit access code per page, which is checked only when mapping is on and the processor runs in slave or master-protected mode. The second is a four-bit write lock per page, which is compared against the four-bit program key on every write. A failed check raises its own violation flag and holds back the memory go signal, so the access ends without touching memory. The trap handling that follows a violation lies outside this block.

All three tables are loaded through one sequential image port. The port takes a start address, then writes one 32-bit image word per beat to successive table groups. Translation and checking are combinational over registered tables.

Top module: `paged_amap`

## Requirements
- R1: With `map_en` low, `pa` equals `va` zero-extended to the real address width.
- R2: With `map_en` high, `pa` is the 11-bit map entry of page `va[16:9]` followed by the offset `va[8:0]`. Map image word g holds the entry for page 2g in bits 10:0 and the entry for page 2g+1 in bits 21:11.
- R3: A `va` below 16 sets `reg_sel`, keeps `mem_go` low and raises no violation. A `va` of 16 or more clears `reg_sel`.
- R4: `prot_viol` is raised only when `map_en` is high and at least one of `slave` or `mprot` is high. In plain master mode, or with mapping off, it stays low.
- R5: The access code denies access as follows. Code 00 denies nothing. Code 01 denies writes. Code 10 denies writes and fetches. Code 11 denies all access. `acc_type` is encoded as read 0, write 1, fetch 2. Access image word g holds page 16g+k in bits 2k+1:2k.
- R6: A page whose lock is 0000 accepts a write under any key. Lock image word g holds page 8g+k in bits 4k+3:4k.
- R7: A key of 0000 opens every lock. A nonzero key passes only when it equals the page's lock. A failing write raises `lock_viol`.
- R8: Reads and fetches never raise `lock_viol`.
- R9: `mem_go` is high exactly when `acc_valid` is high, `reg_sel` is low and neither violation flag is raised. Both flags stay low when `acc_valid` is low.
- R10: The image pointer works as follows. `ld_start` loads the pointer from `ld_addr`. Each `ld_valid` beat writes `ld_word` to the group at the pointer, or at `ld_addr` if `ld_start` is high in the same cycle, and then moves the pointer to that group plus one. `ld_tgt` selects the table: map 0, access 1, lock 2. A write takes effect on the next cycle.
- R11: After reset, every map entry, access code and lock is zero and the image pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented |
| acc_type | input | 2 | Access kind: read 0, write 1, fetch 2 |
| va | input | 17 | Virtual word address |
| map_en | input | 1 | Mapping is in effect |
| slave | input | 1 | Processor is in slave mode |
| mprot | input | 1 | Processor is in master-protected mode |
| key | input | 4 | Program write key |
| ld_start | input | 1 | Load the image pointer from `ld_addr` |
| ld_valid | input | 1 | Write `ld_word` into the selected table |
| ld_tgt | input | 2 | Target table of the image load |
| ld_addr | input | 8 | Starting image group |
| ld_word | input | 32 | Image word |
| pa | output | 20 | Real word address |
| reg_sel | output | 1 | Address selects the general registers |
| prot_viol | output | 1 | Access-code violation |
| lock_viol | output | 1 | Write-lock violation |
| mem_go | output | 1 | Access may proceed to memory |

## Verification
The bench loads all three tables with arithmetic patterns. It then sweeps every page under every access type, every mode combination and three keys per page: zero, the page's own lock, and a wrong key. Pages with a zero lock are covered by the same sweep. The access table is loaded in two passes, upper half first. A pointer that fails to advance, or that ignores a fresh start, would leave codes misplaced and break the sweep on many pages. The register window is probed at 15 and 16, where an off-by-one compare would either send a register access to memory or hide a real page-0 word. A design that gated locks by mode, or applied them to reads, would show spurious violations in master mode or on fetches.

// File: rtl/amap_pkg.sv
package amap_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_kind_e;

   typedef enum logic [1:0] {
      TBL_MAP    = 2'd0,
      TBL_ACCESS = 2'd1,
      TBL_LOCK   = 2'd2
   } tbl_sel_e;

   // Returns 1 when a page's two-bit code refuses the given access kind.
   function automatic logic code_denies(input logic [1:0] code, input logic [1:0] kind);
      logic deny;
      case (code)
         2'b00:   deny = 1'b0;
         2'b01:   deny = (kind == ACC_WRITE);
         2'b10:   deny = (kind != ACC_READ);
         default: deny = 1'b1;
      endcase
      return deny;
   endfunction

endpackage

// File: rtl/amap_table.sv
// Register table filled by packed image words; one group per word.
module amap_table #(
   parameter int ENTRY_W = 4,
   parameter int IDX_W   = 8,
   parameter int WORD_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [IDX_W-1:0]   grp,
   input  logic [WORD_W-1:0]  word,
   input  logic [IDX_W-1:0]   idx,
   output logic [ENTRY_W-1:0] entry
);
   localparam int ENTRIES = 1 << IDX_W;
   localparam int PER     = WORD_W / ENTRY_W;
   localparam int USED_W  = PER * ENTRY_W;

   if (PER < 1) begin : g_bad_width
      $error("amap_table: ENTRY_W must not exceed WORD_W");
   end

   if (USED_W < WORD_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^word[WORD_W-1:USED_W];
   end

   logic [ENTRIES*ENTRY_W-1:0] flat;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      localparam int GRP  = i / PER;
      localparam int SLOT = i % PER;
      logic [ENTRY_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr && grp == IDX_W'(GRP))
            q <= word[SLOT*ENTRY_W +: ENTRY_W];
      end
      assign flat[i*ENTRY_W +: ENTRY_W] = q;
   end

   assign entry = flat[idx*ENTRY_W +: ENTRY_W];

endmodule

// File: rtl/amap_guard.sv
// Access-code and write-lock decision for one access.
module amap_guard
   import amap_pkg::*;
#(
   parameter int KEY_W = 4
) (
   input  logic             acc_valid,
   input  logic [1:0]       acc_type,
   input  logic             reg_sel,
   input  logic             map_en,
   input  logic             slave,
   input  logic             mprot,
   input  logic [1:0]       code,
   input  logic [KEY_W-1:0] lock,
   input  logic [KEY_W-1:0] key,
   output logic             prot_viol,
   output logic             lock_viol
);
   if (KEY_W < 1) begin : g_bad_key
      $error("amap_guard: KEY_W must be positive");
   end

   logic live, gated, denied, is_wr, lock_open;

   always_comb begin
      live      = acc_valid & ~reg_sel;
      gated     = map_en & (slave | mprot);
      denied    = code_denies(code, acc_type);
      is_wr     = (acc_type == ACC_WRITE);
      lock_open = (lock == '0) || (key == '0) || (key == lock);
      prot_viol = live & gated & denied;
      lock_viol = live & is_wr & ~lock_open;
   end

endmodule

// File: rtl/paged_amap.sv
module paged_amap
   import amap_pkg::*;
#(
   parameter int VA_W      = 17,
   parameter int OFS_W     = 9,
   parameter int RPN_W     = 11,
   parameter int KEY_W     = 4,
   parameter int CODE_W    = 2,
   parameter int WORD_W    = 32,
   parameter int REG_LIMIT = 16,
   localparam int VPN_W    = VA_W - OFS_W,
   localparam int PA_W     = RPN_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [1:0]        acc_type,
   input  logic [VA_W-1:0]   va,
   input  logic              map_en,
   input  logic              slave,
   input  logic              mprot,
   input  logic [KEY_W-1:0]  key,
   input  logic              ld_start,
   input  logic              ld_valid,
   input  logic [1:0]        ld_tgt,
   input  logic [VPN_W-1:0]  ld_addr,
   input  logic [WORD_W-1:0] ld_word,
   output logic [PA_W-1:0]   pa,
   output logic              reg_sel,
   output logic              prot_viol,
   output logic              lock_viol,
   output logic              mem_go
);
   if (PA_W < VA_W) begin : g_bad_pa
      $error("paged_amap: real address narrower than virtual address");
   end
   if (CODE_W != 2) begin : g_bad_code
      $error("paged_amap: access codes are two bits wide");
   end

   // Image pointer
   logic [VPN_W-1:0] ptr_q, wr_grp;
   assign wr_grp = ld_start ? ld_addr : ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (ld_valid)
         ptr_q <= wr_grp + VPN_W'(1);
      else if (ld_start)
         ptr_q <= ld_addr;
   end

   // Tables
   logic [VPN_W-1:0]  vpn;
   logic [OFS_W-1:0]  ofs;
   logic [RPN_W-1:0]  rpn;
   logic [CODE_W-1:0] code;
   logic [KEY_W-1:0]  lock;

   assign vpn = va[VA_W-1:OFS_W];
   assign ofs = va[OFS_W-1:0];

   amap_table #(.ENTRY_W(RPN_W), .IDX_W(VPN_W), .WORD_W(WORD_W)) u_map (
      .clk(clk), .rst_n(rst_n),
      .wr(ld_valid && ld_tgt == TBL_MAP),
      .grp(wr_grp), .word(ld_word), .idx(vpn), .entry(rpn)
   );

   amap_table #(.ENTRY_W(CODE_W), .IDX_W(VPN_W), .WORD_W(WORD_W)) u_access (
      .clk(clk), .rst_n(rst_n),
      .wr(ld_valid && ld_tgt == TBL_ACCESS),
      .grp(wr_grp), .word(ld_word), .idx(vpn), .entry(code)
   );

   amap_table #(.ENTRY_W(KEY_W), .IDX_W(VPN_W), .WORD_W(WORD_W)) u_lock (
      .clk(clk), .rst_n(rst_n),
      .wr(ld_valid && ld_tgt == TBL_LOCK),
      .grp(wr_grp), .word(ld_word), .idx(vpn), .entry(lock)
   );

   // Translation
   always_comb begin
      if (map_en)
         pa = {rpn, ofs};
      else
         pa = PA_W'(va);
   end

   if (REG_LIMIT > 0) begin : g_regwin
      assign reg_sel = (va < VA_W'(REG_LIMIT));
   end else begin : g_noregwin
      assign reg_sel = 1'b0;
   end

   // Checks
   amap_guard #(.KEY_W(KEY_W)) u_guard (
      .acc_valid(acc_valid), .acc_type(acc_type), .reg_sel(reg_sel),
      .map_en(map_en), .slave(slave), .mprot(mprot),
      .code(code), .lock(lock), .key(key),
      .prot_viol(prot_viol), .lock_viol(lock_viol)
   );

   assign mem_go = acc_valid & ~reg_sel & ~prot_viol & ~lock_viol;

endmodule

// File: rtl/paged_amap_props.sv
module paged_amap_props #(
   parameter int VA_W  = 17,
   parameter int VPN_W = 8,
   parameter int PA_W  = 20,
   parameter int KEY_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic [1:0]       acc_type,
   input logic [VA_W-1:0]  va,
   input logic             map_en,
   input logic             slave,
   input logic             mprot,
   input logic [KEY_W-1:0] key,
   input logic             ld_start,
   input logic             ld_valid,
   input logic [VPN_W-1:0] ld_addr,
   input logic [VPN_W-1:0] ptr_q,
   input logic [PA_W-1:0]  pa,
   input logic             reg_sel,
   input logic             prot_viol,
   input logic             lock_viol,
   input logic             mem_go
);
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !map_en |-> pa == PA_W'(va)); // R1
   AST_REG_NOT_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel |-> (!mem_go && !prot_viol && !lock_viol)); // R3
   AST_MASTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!map_en || (!slave && !mprot)) |-> !prot_viol); // R4
   AST_KEY_ZERO_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (key == '0) |-> !lock_viol); // R7
   AST_READ_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_type != 2'd1) |-> !lock_viol); // R8
   AST_VIOL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_viol || lock_viol) |-> !mem_go); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!mem_go && !prot_viol && !lock_viol)); // R9
   AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> ptr_q == VPN_W'($past(ld_start ? ld_addr : ptr_q) + VPN_W'(1))); // R10
endmodule

bind paged_amap paged_amap_props #(
   .VA_W(VA_W), .VPN_W(VPN_W), .PA_W(PA_W), .KEY_W(KEY_W)
) u_props (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_type(acc_type),
   .va(va), .map_en(map_en), .slave(slave), .mprot(mprot), .key(key),
   .ld_start(ld_start), .ld_valid(ld_valid), .ld_addr(ld_addr), .ptr_q(ptr_q),
   .pa(pa), .reg_sel(reg_sel), .prot_viol(prot_viol), .lock_viol(lock_viol),
   .mem_go(mem_go)
);

// File: tb/paged_amap_test.sv
module paged_amap_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [1:0]  acc_type = 2'd0;
   logic [16:0] va = '0;
   logic        map_en = 1'b0, slave = 1'b0, mprot = 1'b0;
   logic [3:0]  key = '0;
   logic        ld_start = 1'b0, ld_valid = 1'b0;
   logic [1:0]  ld_tgt = 2'd0;
   logic [7:0]  ld_addr = '0;
   logic [31:0] ld_word = '0;
   logic [19:0] pa;
   logic        reg_sel, prot_viol, lock_viol, mem_go;

   int n_chk = 0;
   int n_bad = 0;
   bit reported = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   paged_amap uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_type(acc_type),
      .va(va), .map_en(map_en), .slave(slave), .mprot(mprot), .key(key),
      .ld_start(ld_start), .ld_valid(ld_valid), .ld_tgt(ld_tgt),
      .ld_addr(ld_addr), .ld_word(ld_word),
      .pa(pa), .reg_sel(reg_sel), .prot_viol(prot_viol),
      .lock_viol(lock_viol), .mem_go(mem_go)
   );

   function automatic logic [10:0] rpn_of(input int v);
      return 11'((v * 37 + 5) & 'h7FF);
   endfunction
   function automatic logic [1:0] code_of(input int v);
      return 2'((v * 5 + v / 16) & 3);
   endfunction
   function automatic logic [3:0] lock_of(input int v);
      return 4'((v * 3) & 15);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
   endtask

   task automatic ld(input logic first, input logic [1:0] tgt,
                     input logic [7:0] a, input logic [31:0] w);
      @(negedge clk);
      ld_start = first; ld_valid = 1'b1; ld_tgt = tgt; ld_addr = a; ld_word = w;
      @(negedge clk);
      ld_start = 1'b0; ld_valid = 1'b0;
   endtask

   // Drive one access, then compare all outputs against the arithmetic model.
   task automatic probe(input string req, input int v, input int off, input logic [1:0] typ,
                        input int m, input logic [3:0] k, input logic men);
      logic [16:0] vv;
      logic rs, gate, deny, pv, lv, go;
      logic [19:0] epa;
      logic [1:0] c;
      logic [3:0] lk;
      vv = {v[7:0], off[8:0]};
      acc_valid = 1'b1; acc_type = typ; va = vv; map_en = men;
      slave = m[0]; mprot = m[1]; key = k;
      #1;
      c  = code_of(v);
      lk = lock_of(v);
      rs = (vv < 17'd16);
      gate = men && (m != 0);
      case (c)
         2'b00: deny = 1'b0;
         2'b01: deny = (typ == 2'd1);
         2'b10: deny = (typ != 2'd0);
         default: deny = 1'b1;
      endcase
      pv  = !rs && gate && deny;
      lv  = !rs && (typ == 2'd1) && (lk != 0) && (k != 0) && (k != lk);
      go  = !rs && !pv && !lv;
      epa = men ? {rpn_of(v), off[8:0]} : {3'b000, vv};
      check(req, {8'h00, pa, reg_sel, prot_viol, lock_viol, mem_go},
                 {8'h00, epa, rs, pv, lv, go});
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: cleared tables -> page 0, code 00, lock 0
      acc_valid = 1'b1; acc_type = 2'd1; va = {8'd77, 9'd300};
      map_en = 1'b1; slave = 1'b1; mprot = 1'b0; key = 4'd9;
      #1;
      check("R11 reset tables", {8'h00, pa, reg_sel, prot_viol, lock_viol, mem_go},
            {8'h00, 11'd0, 9'd300, 1'b0, 1'b0, 1'b0, 1'b1});
      acc_valid = 1'b0;
      #1;
      // R9: idle access
      check("R9 idle", {28'd0, reg_sel, prot_viol, lock_viol, mem_go}, 32'd0);

      // R10 R2: map loaded by one start then 128 consecutive beats
      for (int g = 0; g < 128; g++)
         ld(g == 0, 2'd0, 8'd0, {10'd0, rpn_of(2*g+1), rpn_of(2*g)});
      // R10 R5: access table in two passes, upper half first
      for (int g = 8; g < 16; g++) begin
         logic [31:0] w = '0;
         for (int k = 0; k < 16; k++) w[2*k +: 2] = code_of(16*g + k);
         ld(g == 8, 2'd1, 8'd8, w);
      end
      for (int g = 0; g < 8; g++) begin
         logic [31:0] w = '0;
         for (int k = 0; k < 16; k++) w[2*k +: 2] = code_of(16*g + k);
         ld(g == 0, 2'd1, 8'd0, w);
      end
      // R10 R6: lock table
      for (int g = 0; g < 32; g++) begin
         logic [31:0] w = '0;
         for (int k = 0; k < 8; k++) w[4*k +: 4] = lock_of(8*g + k);
         ld(g == 0, 2'd2, 8'd0, w);
      end
      @(negedge clk);

      // R3: register window edge
      probe("R3 va15", 0, 15, 2'd1, 1, 4'd3, 1'b1);
      probe("R3 va16", 0, 16, 2'd1, 1, 4'd3, 1'b1);
      probe("R3 va0 read", 0, 0, 2'd0, 0, 4'd0, 1'b0);

      // R2 R4 R5 R6 R7 R8 R9: full sweep with mapping on
      for (int v = 0; v < 256; v++) begin
         for (int t = 0; t < 3; t++) begin
            for (int m = 0; m < 4; m++) begin
               logic [3:0] lk = lock_of(v);
               probe("R2 R4 R5 R9 key0 R7", v, (v*13) & 511, 2'(t), m, 4'd0, 1'b1);
               probe("R6 R7 R8 own key", v, (v*13) & 511, 2'(t), m, lk, 1'b1);
               probe("R6 R7 R8 wrong key", v, (v*13) & 511, 2'(t), m, lk ^ 4'd4, 1'b1);
            end
         end
      end

      // R1 R4: mapping off, slave mode, writes with a wrong key
      for (int v = 0; v < 256; v++)
         for (int t = 0; t < 3; t++)
            probe("R1 R4 unmapped", v, (v*29 + 7) & 511, 2'(t), 1, lock_of(v) ^ 4'd8, 1'b0);

      acc_valid = 1'b0;
      report();
      $finish;
   end

endmodule